// File: doc/BRIEF.md
# Four-Slot Same-Cycle Register Renamer

This block renames a group of up to four instructions per clock. Each slot carries two architectural source register numbers, an architectural destination number and a flag that says whether the slot writes a destination at all. Each destination that is written gets a fresh physical tag. The tags come from a first-in first-out free list and are handed out in slot order. Sources are mapped to physical tags through a map table indexed by architectural register.

Dependences inside one group are resolved in the same cycle. A source reads the tag that the youngest earlier slot of the group has just assigned to the same architectural register. If no earlier slot wrote that register, the source reads the map table. One architectural register may be written by several slots of a group, and the map table keeps the youngest of those mappings. If the free list holds fewer tags than the group needs, the whole group stalls. A stalled group changes nothing, and the sender holds it and presents it again. Freed tags come back one per cycle through a release port.

Top module: `group_renamer`

## Requirements
- R1: After reset, architectural register k maps to physical tag k. The free list holds tags ARCH_REGS through PHYS_REGS-1, and the first allocation returns ARCH_REGS. out_valid and stall are both low.
- R2: An accepted group gets its results on the clock edge that accepts it, so they are visible in the following cycle with out_valid high. Each slot with a destination receives the next free tag in slot order, from slot 0 to slot 3. Slot i occupies bits [i*6 +: 6] of out_dst.
- R3: A source with no earlier writer of its register in the same group gets the map table entry. A slot's own destination does not affect its own sources.
- R4: A source whose register is written by an earlier slot in the group gets the tag of the youngest such earlier slot.
- R5: When several slots of a group write the same architectural register, later groups see the tag given to the youngest of those slots.
- R6: stall is high in the same cycle when in_valid is high and the number of enabled destinations exceeds the free tag count. A stalled group produces no output and changes neither the map table nor the free list.
- R7: A slot with its destination flag low uses no free tag. Its out_dst_en bit is low.
- R8: A released tag is appended at the tail of the free list and can be allocated from the next cycle on. It is allocated only after the tags already in the list. A release is dropped when the list is full.
- R9: While in_valid is low, out_valid goes low in the next cycle and the map table is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A group is presented this cycle |
| in_src_a | input | 20 | First source register of each slot, 5 bits per slot |
| in_src_b | input | 20 | Second source register of each slot, 5 bits per slot |
| in_dst | input | 20 | Destination register of each slot, 5 bits per slot |
| in_dst_en | input | 4 | Slot writes a destination |
| rel_valid | input | 1 | Return one tag to the free list |
| rel_tag | input | 6 | Tag being returned |
| stall | output | 1 | Group cannot be renamed this cycle |
| out_valid | output | 1 | Renamed group is on the outputs |
| out_src_a | output | 24 | Physical tag of each first source, 6 bits per slot |
| out_src_b | output | 24 | Physical tag of each second source, 6 bits per slot |
| out_dst | output | 24 | New physical tag of each destination, 6 bits per slot |
| out_dst_en | output | 4 | Slot received a destination tag |

## Verification
A corrupted map entry shows up as a wrong source tag on the next group that reads that register without an earlier writer in its own group. It appears one cycle after that group is accepted. A wrong free-list pointer or count shows up at once as a wrong destination tag or as a stall decision that differs from the reference. The reference model follows every allocation and release, so an error in either one appears within a few groups. A broken bypass priority shows up as a wrong source tag in the same group that exposes it, for example the repeated writes to r1 in the add/sub/lw/add example.

// File: rtl/group_renamer.sv
module group_renamer #(
  parameter int SLOTS     = 4,
  parameter int ARCH_REGS = 32,
  parameter int PHYS_REGS = 64
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                in_valid,
  input  logic [SLOTS*$clog2(ARCH_REGS)-1:0]  in_src_a,
  input  logic [SLOTS*$clog2(ARCH_REGS)-1:0]  in_src_b,
  input  logic [SLOTS*$clog2(ARCH_REGS)-1:0]  in_dst,
  input  logic [SLOTS-1:0]                    in_dst_en,
  input  logic                                rel_valid,
  input  logic [$clog2(PHYS_REGS)-1:0]        rel_tag,
  output logic                                stall,
  output logic                                out_valid,
  output logic [SLOTS*$clog2(PHYS_REGS)-1:0]  out_src_a,
  output logic [SLOTS*$clog2(PHYS_REGS)-1:0]  out_src_b,
  output logic [SLOTS*$clog2(PHYS_REGS)-1:0]  out_dst,
  output logic [SLOTS-1:0]                    out_dst_en
);
  localparam int AW        = $clog2(ARCH_REGS);
  localparam int PW        = $clog2(PHYS_REGS);
  localparam int CW        = PW + 1;
  localparam int INIT_FREE = PHYS_REGS - ARCH_REGS;

  logic [PW-1:0] map_q [ARCH_REGS];
  logic [PW-1:0] fl_q  [PHYS_REGS];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] fl_count;

  logic [CW-1:0] need;
  logic [PW-1:0] fresh [SLOTS];
  logic [SLOTS*PW-1:0] tag_a, tag_b, tag_d;
  logic accept, rel_ok;
  logic [CW-1:0] pop_n;

  always_comb begin
    need = '0;
    for (int i = 0; i < SLOTS; i++) begin
      fresh[i] = fl_q[rd_ptr + need[PW-1:0]];
      if (in_dst_en[i]) need = need + CW'(1);
    end
  end

  always_comb begin
    for (int i = 0; i < SLOTS; i++) begin
      tag_a[i*PW +: PW] = map_q[in_src_a[i*AW +: AW]];
      tag_b[i*PW +: PW] = map_q[in_src_b[i*AW +: AW]];
      tag_d[i*PW +: PW] = in_dst_en[i] ? fresh[i] : '0;
      for (int j = 0; j < SLOTS; j++) begin
        if (j < i && in_dst_en[j]) begin
          if (in_dst[j*AW +: AW] == in_src_a[i*AW +: AW]) tag_a[i*PW +: PW] = fresh[j];
          if (in_dst[j*AW +: AW] == in_src_b[i*AW +: AW]) tag_b[i*PW +: PW] = fresh[j];
        end
      end
    end
  end

  assign stall  = in_valid && (need > fl_count);
  assign accept = in_valid && !stall;
  assign rel_ok = rel_valid && (fl_count != CW'(PHYS_REGS));
  assign pop_n  = accept ? need : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < ARCH_REGS; k++) map_q[k] <= PW'(k);
      for (int k = 0; k < PHYS_REGS; k++) fl_q[k] <= (k < INIT_FREE) ? PW'(k + ARCH_REGS) : '0;
      rd_ptr     <= '0;
      wr_ptr     <= PW'(INIT_FREE);
      fl_count   <= CW'(INIT_FREE);
      out_valid  <= 1'b0;
      out_src_a  <= '0;
      out_src_b  <= '0;
      out_dst    <= '0;
      out_dst_en <= '0;
    end else begin
      out_valid <= accept;
      if (accept) begin
        for (int j = 0; j < SLOTS; j++)
          if (in_dst_en[j]) map_q[in_dst[j*AW +: AW]] <= fresh[j];
        out_src_a  <= tag_a;
        out_src_b  <= tag_b;
        out_dst    <= tag_d;
        out_dst_en <= in_dst_en;
        rd_ptr     <= rd_ptr + need[PW-1:0];
      end
      if (rel_ok) begin
        fl_q[wr_ptr] <= rel_tag;
        wr_ptr       <= wr_ptr + PW'(1);
      end
      fl_count <= fl_count - pop_n + (rel_ok ? CW'(1) : CW'(0));
    end
  end
endmodule

// File: rtl/renamer_checks.sv
module renamer_checks #(
  parameter int SLOTS     = 4,
  parameter int PHYS_REGS = 64
) (
  input logic                                clk,
  input logic                                rst_n,
  input logic                                in_valid,
  input logic [SLOTS-1:0]                    in_dst_en,
  input logic                                rel_valid,
  input logic                                stall,
  input logic                                out_valid,
  input logic [SLOTS*$clog2(PHYS_REGS)-1:0]  out_dst,
  input logic [SLOTS-1:0]                    out_dst_en,
  input logic [$clog2(PHYS_REGS):0]          fl_count
);
  localparam int PW = $clog2(PHYS_REGS);

  p_stall_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !out_valid);

  p_stall_keeps_list_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !rel_valid) |=> fl_count == $past(fl_count));

  p_accept_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !stall) |=> out_valid);

  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  p_no_dst_no_tag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !stall && in_dst_en == '0 && !rel_valid) |=> fl_count == $past(fl_count));

  p_release_grows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && rel_valid && fl_count < ($clog2(PHYS_REGS)+1)'(PHYS_REGS))
      |=> fl_count == $past(fl_count) + 1'b1);

  for (genvar i = 0; i < SLOTS; i++) begin : g_a
    for (genvar j = i + 1; j < SLOTS; j++) begin : g_b
      p_unique_dst_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_dst_en[i] && out_dst_en[j])
          |-> out_dst[i*PW +: PW] != out_dst[j*PW +: PW]);
    end
  end
endmodule

bind group_renamer renamer_checks #(.SLOTS(SLOTS), .PHYS_REGS(PHYS_REGS)) u_checks (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dst_en(in_dst_en),
  .rel_valid(rel_valid), .stall(stall), .out_valid(out_valid),
  .out_dst(out_dst), .out_dst_en(out_dst_en), .fl_count(fl_count));

// File: tb/tb_group_renamer.sv
module tb_group_renamer;
  localparam int S = 4, A = 32, P = 64, AW = 5, PW = 6;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, in_valid, rel_valid, stall, out_valid;
  logic [S*AW-1:0] in_src_a, in_src_b, in_dst;
  logic [S-1:0] in_dst_en, out_dst_en;
  logic [PW-1:0] rel_tag;
  logic [S*PW-1:0] out_src_a, out_src_b, out_dst;

  group_renamer dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_src_a(in_src_a),
    .in_src_b(in_src_b), .in_dst(in_dst), .in_dst_en(in_dst_en),
    .rel_valid(rel_valid), .rel_tag(rel_tag), .stall(stall),
    .out_valid(out_valid), .out_src_a(out_src_a), .out_src_b(out_src_b),
    .out_dst(out_dst), .out_dst_en(out_dst_en));

  int compared = 0, mismatched = 0;
  bit finished = 0;
  int map_m [A];
  int fq[$];
  int inflight[$];

  task automatic chk(input string req, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input bit v, input int sa[4], input int sb[4], input int d[4],
                      input bit [3:0] en, input bit rv, input int rt);
    int need, k;
    bit exp_stall, acc, room;
    int fresh[4];
    int ea[4], eb[4];
    bit ba[4], bb[4];
    @(negedge clk);
    in_valid = v;
    for (int i = 0; i < S; i++) begin
      in_src_a[i*AW +: AW] = AW'(sa[i]);
      in_src_b[i*AW +: AW] = AW'(sb[i]);
      in_dst[i*AW +: AW]   = AW'(d[i]);
    end
    in_dst_en = en;
    rel_valid = rv;
    rel_tag   = PW'(rt);
    #1;
    need = 0;
    for (int i = 0; i < S; i++) if (en[i]) need++;
    exp_stall = v && (need > fq.size());
    chk("R6", "stall", int'(stall), int'(exp_stall));
    acc  = v && !exp_stall;
    room = fq.size() < P;
    if (acc) begin
      k = 0;
      for (int i = 0; i < S; i++) begin
        fresh[i] = 0;
        if (en[i]) begin fresh[i] = fq[k]; k++; end
      end
      for (int i = 0; i < S; i++) begin
        ea[i] = map_m[sa[i]]; ba[i] = 0;
        eb[i] = map_m[sb[i]]; bb[i] = 0;
        for (int j = 0; j < i; j++) begin
          if (en[j] && d[j] == sa[i]) begin ea[i] = fresh[j]; ba[i] = 1; end
          if (en[j] && d[j] == sb[i]) begin eb[i] = fresh[j]; bb[i] = 1; end
        end
      end
      repeat (need) void'(fq.pop_front());
      for (int i = 0; i < S; i++)
        if (en[i]) begin map_m[d[i]] = fresh[i]; inflight.push_back(fresh[i]); end
    end
    if (rv && room) fq.push_back(rt);
    @(posedge clk);
    #2;
    chk("R9", "out_valid", int'(out_valid), int'(acc));
    if (acc) begin
      for (int i = 0; i < S; i++) begin
        chk(ba[i] ? "R4" : "R3", "src_a tag", int'(out_src_a[i*PW +: PW]), ea[i]);
        chk(bb[i] ? "R4" : "R3", "src_b tag", int'(out_src_b[i*PW +: PW]), eb[i]);
        chk("R7", "dst_en", int'(out_dst_en[i]), int'(en[i]));
        if (en[i]) chk("R2", "dst tag", int'(out_dst[i*PW +: PW]), fresh[i]);
      end
    end
  endtask

  task automatic idle_release(input int rt);
    step(0, '{0,0,0,0}, '{0,0,0,0}, '{0,0,0,0}, 4'b0000, 1, rt);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 0; in_valid = 0; rel_valid = 0; rel_tag = '0;
    in_src_a = '0; in_src_b = '0; in_dst = '0; in_dst_en = '0;
    for (int i = 0; i < A; i++) map_m[i] = i;
    for (int t = A; t < P; t++) fq.push_back(t);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    // R1: reset state at the ports
    chk("R1", "out_valid after reset", int'(out_valid), 0);
    chk("R1", "stall after reset", int'(stall), 0);

    // add r1,r2,r3 / sub r4,r1,r2 / lw r1,4(r4) / add r5,r1,r2
    step(1, '{2,1,4,1}, '{3,2,0,2}, '{1,4,1,5}, 4'b1111, 0, 0);
    chk("R1", "first fresh tag", int'(out_dst[0 +: PW]), 32);
    chk("R1", "identity map r2", int'(out_src_a[0 +: PW]), 2);
    chk("R4", "sub reads r1 from slot0", int'(out_src_a[1*PW +: PW]), 32);
    chk("R4", "lw reads r4 from slot1", int'(out_src_a[2*PW +: PW]), 33);
    chk("R4", "last add reads youngest r1", int'(out_src_a[3*PW +: PW]), 34);

    // R5: r1 in the map now holds the lw tag
    step(1, '{1,5,4,0}, '{1,2,3,0}, '{0,0,0,0}, 4'b0000, 0, 0);
    chk("R5", "r1 after double write", int'(out_src_a[0 +: PW]), 34);

    // R5: three writes to r7 in one group, read next group
    step(1, '{0,7,0,7}, '{0,0,0,0}, '{7,7,3,7}, 4'b1011, 0, 0);
    step(1, '{7,3,7,9}, '{9,7,1,9}, '{9,9,0,0}, 4'b0011, 0, 0);
    // R3: own destination does not affect own source
    step(1, '{9,9,0,0}, '{9,9,0,0}, '{9,9,0,0}, 4'b0001, 0, 0);
    // R7: group without destinations, then next tag continues in order
    step(1, '{1,2,3,4}, '{5,6,7,8}, '{1,2,3,4}, 4'b0000, 0, 0);
    step(1, '{1,2,3,4}, '{5,6,7,8}, '{10,11,12,13}, 4'b0101, 0, 0);

    // R6: drain the free list until the group stalls
    for (int n = 0; n < 10; n++)
      step(1, '{n%A,(n+3)%A,(n+5)%A,1}, '{2,3,4,5}, '{(n+20)%A,(n+21)%A,(n+22)%A,(n+23)%A}, 4'b1111, 0, 0);
    step(1, '{1,2,3,4}, '{5,6,7,8}, '{1,2,3,4}, 4'b1111, 0, 0);
    step(1, '{20,21,22,23}, '{24,25,26,27}, '{0,0,0,0}, 4'b0000, 0, 0);

    // R8 and R9: returns while idle, then allocate them in order
    for (int r = 0; r < 3; r++) idle_release(inflight.pop_front());
    step(1, '{1,2,3,4}, '{5,6,7,8}, '{14,15,16,17}, 4'b0111, 0, 0);
    step(1, '{14,15,16,17}, '{0,0,0,0}, '{0,0,0,0}, 4'b0000, 0, 0);
    // R8: a release is not available in the cycle it arrives
    step(1, '{1,2,3,4}, '{5,6,7,8}, '{18,0,0,0}, 4'b0001, 1, inflight.pop_front());
    step(1, '{18,2,3,4}, '{5,6,7,8}, '{18,0,0,0}, 4'b0001, 0, 0);

    // mixed traffic
    for (int n = 0; n < 600; n++) begin
      int ra[4], rb[4], rd[4];
      bit rv;
      int rt;
      for (int i = 0; i < S; i++) begin
        ra[i] = $urandom_range(A-1);
        rb[i] = $urandom_range(A-1);
        rd[i] = $urandom_range(7);
      end
      rv = (inflight.size() > 0) && ($urandom_range(2) != 0);
      rt = rv ? inflight.pop_front() : 0;
      step($urandom_range(3) != 0, ra, rb, rd, 4'($urandom_range(15)), rv, rt);
    end

    @(negedge clk);
    in_valid = 0; rel_valid = 0;
    finish_run();
  end
endmodule